// File: doc/BRIEF.md
# Banked System Address Map Decoder

This block takes a 24-bit processor address, made of an 8-bit bank and a 16-bit offset, and decides which on-chip region owns it. Ownership is resolved on 4 KiB pages, so only address bits 23:12 pick the region. The low 12 bits pass through only into the local work RAM address. Three targets exist: the 128 KiB work RAM, the register window, and everything else. Everything else is reported as unmapped and left to an external decoder, such as cartridge logic.

The work RAM is reachable in two ways. Two dedicated banks map linearly onto the whole RAM. The bottom 8 KiB of every system bank mirrors the start of the RAM. For an unmapped page the block also produces an open-bus byte taken from the page number. The downstream read mux can return that byte instead of zero.

The decode is combinational and is followed by one register stage. The stage loads only when a request is presented, so every result appears exactly one clock after its request and is held until the next one.

Top module: `sysmap_decoder`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request, `out_valid` is 0, `out_sel` is 3'b000, `out_wram_addr` is 0, `out_unmapped` is 0 and `out_open_bus` is 0.
- R2: A request presented with `in_valid` high at a rising edge gives `out_valid` high after that edge. A cycle with `in_valid` low gives `out_valid` low and leaves `out_sel`, `out_wram_addr`, `out_unmapped` and `out_open_bus` unchanged.
- R3: In banks 0x7E and 0x7F, every offset selects work RAM (`out_sel` = 3'b001). `out_wram_addr` is {bank bit 0, offset}, which covers 0x00000 to 0x1FFFF.
- R4: In system banks (0x00 to 0x3F and 0x80 to 0xBF), offsets 0x0000 to 0x1FFF select work RAM (`out_sel` = 3'b001). `out_wram_addr` is offset bits 12:0, zero-extended.
- R5: In system banks, offsets 0x2000 to 0x2FFF and 0x4000 to 0x4FFF select the register window (`out_sel` = 3'b010).
- R6: Every other address is unmapped: `out_sel` = 3'b100 and `out_unmapped` = 1. This covers banks 0x40 to 0x7D and 0xC0 to 0xFF, and the system-bank pages at 0x3000 and at 0x5000 and above.
- R7: For an unmapped address, `out_open_bus` equals address bits 19:12. For a mapped address it is 0.
- R8: For every valid result `out_sel` is one-hot, no page is claimed by more than one region, and the region depends only on address bits 23:12.
- R9: `out_wram_addr` is 0 whenever the region is not work RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with `clk` |
| in_valid | input | 1 | A request is present this cycle |
| in_addr | input | 24 | Address: bank in bits 23:16, offset in bits 15:0 |
| out_valid | output | 1 | Registered result is for the previous cycle's request |
| out_sel | output | 3 | One-hot region: bit 0 work RAM, bit 1 register window, bit 2 unmapped |
| out_wram_addr | output | 17 | Local work RAM byte address |
| out_unmapped | output | 1 | No region here claims the page |
| out_open_bus | output | 8 | Open-bus byte for an unmapped page |

## Verification
The assertions assume that `rst_n` is released in step with `clk` and that `in_valid` and `in_addr` are stable around each rising edge. The bench drives inputs only on falling edges and keeps `in_valid` low during reset. It assumes that `in_addr` is at a known value whenever `in_valid` is high, which the bench guarantees by setting the address in the same step as the valid bit. The directed addresses sit on page and bank boundaries: first and last byte of each window, and the banks just outside the system and linear ranges. These boundaries are where a wrong comparison would show up.

// File: rtl/sysmap_pkg.sv
package sysmap_pkg;
  localparam int unsigned BANK_W     = 8;
  localparam int unsigned OFF_W      = 16;
  localparam int unsigned ADDR_W     = BANK_W + OFF_W;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned PAGE_W     = OFF_W - PAGE_SHIFT;
  localparam int unsigned WRAM_AW    = 17;
  localparam int unsigned OB_W       = 8;

  // index of each region inside the one-hot select
  typedef enum int unsigned {
    RGN_WRAM = 0,
    RGN_REGS = 1,
    RGN_EXT  = 2
  } region_e;

  localparam int unsigned RGN_N = 3;

  typedef struct packed {
    logic [RGN_N-1:0]   sel;
    logic [WRAM_AW-1:0] wram_addr;
    logic               unmapped;
    logic [OB_W-1:0]    open_bus;
  } map_result_t;
endpackage

// File: rtl/sysmap_bank_class.sv
module sysmap_bank_class
  import sysmap_pkg::*;
#(
  parameter logic [BANK_W-1:0] SYS_MASK  = 8'h40,
  parameter logic [BANK_W-1:0] SYS_MATCH = 8'h00
) (
  input  logic [BANK_W-1:0] bank,
  output logic              is_system
);
  // system banks: those whose masked bits match (0x00-0x3F and 0x80-0xBF)
  always_comb begin
    is_system = ((bank & SYS_MASK) == SYS_MATCH);
  end
endmodule

// File: rtl/sysmap_ram_claim.sv
module sysmap_ram_claim
  import sysmap_pkg::*;
#(
  parameter logic [BANK_W-1:0] LINEAR_BASE  = 8'h7E,
  parameter int unsigned       MIRROR_PAGES = 2
) (
  input  logic [BANK_W-1:0]  bank,
  input  logic [OFF_W-1:0]   offset,
  input  logic               is_system,
  output logic               claim,
  output logic [WRAM_AW-1:0] wram_addr
);
  localparam int unsigned LIN_BANK_BITS = WRAM_AW - OFF_W;
  localparam int unsigned MIRROR_AW     = PAGE_SHIFT + $clog2(MIRROR_PAGES);
  localparam int unsigned MIRROR_PAD    = WRAM_AW - MIRROR_AW;

  logic              lin_hit;
  logic              mir_hit;
  logic [PAGE_W-1:0] page;

  always_comb begin
    page    = offset[OFF_W-1:PAGE_SHIFT];
    lin_hit = (bank[BANK_W-1:LIN_BANK_BITS] == LINEAR_BASE[BANK_W-1:LIN_BANK_BITS]);
    mir_hit = is_system && (32'(page) < MIRROR_PAGES);
    claim   = lin_hit | mir_hit;
    if (lin_hit) begin
      wram_addr = {bank[LIN_BANK_BITS-1:0], offset};
    end else if (mir_hit) begin
      wram_addr = {{MIRROR_PAD{1'b0}}, offset[MIRROR_AW-1:0]};
    end else begin
      wram_addr = '0;
    end
  end
endmodule

// File: rtl/sysmap_reg_claim.sv
module sysmap_reg_claim
  import sysmap_pkg::*;
#(
  // one bit per page of a system bank that belongs to the register window
  parameter logic [(1<<PAGE_W)-1:0] REG_PAGES = 16'h0014
) (
  input  logic [PAGE_W-1:0] page,
  input  logic              is_system,
  output logic              claim
);
  localparam int unsigned NPAGE = 1 << PAGE_W;

  logic [NPAGE-1:0] hit;

  generate
    for (genvar p = 0; p < NPAGE; p++) begin : g_page
      if (REG_PAGES[p]) begin : g_on
        assign hit[p] = (page == PAGE_W'(p));
      end else begin : g_off
        assign hit[p] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    claim = is_system && (|hit);
  end
endmodule

// File: rtl/sysmap_decoder.sv
module sysmap_decoder
  import sysmap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [ADDR_W-1:0]   in_addr,
  output logic                out_valid,
  output logic [RGN_N-1:0]    out_sel,
  output logic [WRAM_AW-1:0]  out_wram_addr,
  output logic                out_unmapped,
  output logic [OB_W-1:0]     out_open_bus
);
  logic [BANK_W-1:0]  bank;
  logic [OFF_W-1:0]   offset;
  logic               is_system;
  logic               ram_claim;
  logic               reg_claim;
  logic [WRAM_AW-1:0] ram_addr;
  map_result_t        res_next;
  map_result_t        res_q;
  logic               valid_q;

  assign bank   = in_addr[ADDR_W-1:OFF_W];
  assign offset = in_addr[OFF_W-1:0];

  sysmap_bank_class u_class (
    .bank      (bank),
    .is_system (is_system)
  );

  sysmap_ram_claim u_ram (
    .bank      (bank),
    .offset    (offset),
    .is_system (is_system),
    .claim     (ram_claim),
    .wram_addr (ram_addr)
  );

  sysmap_reg_claim u_regs (
    .page      (offset[OFF_W-1:PAGE_SHIFT]),
    .is_system (is_system),
    .claim     (reg_claim)
  );

  // resolve claims into a result
  always_comb begin
    res_next = '0;
    if (ram_claim) begin
      res_next.sel[RGN_WRAM] = 1'b1;
      res_next.wram_addr     = ram_addr;
    end else if (reg_claim) begin
      res_next.sel[RGN_REGS] = 1'b1;
    end else begin
      res_next.sel[RGN_EXT]  = 1'b1;
      res_next.unmapped      = 1'b1;
      res_next.open_bus      = in_addr[PAGE_SHIFT+OB_W-1:PAGE_SHIFT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        res_q <= res_next;
      end
    end
  end

  assign out_valid     = valid_q;
  assign out_sel       = res_q.sel;
  assign out_wram_addr = res_q.wram_addr;
  assign out_unmapped  = res_q.unmapped;
  assign out_open_bus  = res_q.open_bus;

  AST_CLAIM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0({ram_claim, reg_claim})) // R8
    else $error("two regions claim one page");
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot(out_sel)) // R8
    else $error("select not one-hot");
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) // R2
    else $error("valid lost");
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_sel) && $stable(out_wram_addr))) // R2
    else $error("idle cycle changed result");
  AST_LINEAR_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr[23:17] == 7'h3F) |=> (out_sel == 3'b001 &&
      out_wram_addr == $past(in_addr[16:0]))) // R3
    else $error("linear bank misdecoded");
  AST_OPENBUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_unmapped) |-> (out_open_bus == '0)) // R7
    else $error("open bus driven on mapped page");
  AST_WRAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sel[RGN_WRAM]) |-> (out_wram_addr == '0)) // R9
    else $error("work RAM address on other region");
endmodule

// File: tb/sysmap_decoder_bench.sv
module sysmap_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_addr = '0;
  logic        out_valid;
  logic [2:0]  out_sel;
  logic [16:0] out_wram_addr;
  logic        out_unmapped;
  logic [7:0]  out_open_bus;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sysmap_decoder u_sysmap_decoder (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_addr       (in_addr),
    .out_valid     (out_valid),
    .out_sel       (out_sel),
    .out_wram_addr (out_wram_addr),
    .out_unmapped  (out_unmapped),
    .out_open_bus  (out_open_bus)
  );

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // present one request, then sample the registered result one edge later
  task automatic probe(input string req, input logic [23:0] a, input logic [2:0] sel,
                       input logic [16:0] wa, input logic [7:0] ob);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    @(negedge clk);
    in_valid = 1'b0;
    cmp(req, "valid", 32'(out_valid), 32'd1);
    cmp(req, "sel", 32'(out_sel), 32'(sel));
    cmp(req, "wram_addr", 32'(out_wram_addr), 32'(wa));
    cmp(req, "unmapped", 32'(out_unmapped), 32'(sel == 3'b100));
    cmp(req, "open_bus", 32'(out_open_bus), 32'(ob));
  endtask

  task automatic t_reset;
    cmp("R1", "valid in reset", 32'(out_valid), 32'd0);
    cmp("R1", "sel in reset", 32'(out_sel), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cmp("R1", "valid idle", 32'(out_valid), 32'd0);
    cmp("R1", "sel idle", 32'(out_sel), 32'd0);
    cmp("R1", "wram idle", 32'(out_wram_addr), 32'd0);
    cmp("R1", "unmapped idle", 32'(out_unmapped), 32'd0);
    cmp("R1", "open bus idle", 32'(out_open_bus), 32'd0);
  endtask

  task automatic t_linear; // R3
    probe("R3", 24'h7E0000, 3'b001, 17'h00000, 8'h00);
    probe("R3", 24'h7EFFFF, 3'b001, 17'h0FFFF, 8'h00);
    probe("R3", 24'h7F0000, 3'b001, 17'h10000, 8'h00);
    probe("R3", 24'h7FFFFF, 3'b001, 17'h1FFFF, 8'h00);
    probe("R3", 24'h7F2345, 3'b001, 17'h12345, 8'h00);
  endtask

  task automatic t_mirror; // R4, R9
    probe("R4", 24'h000000, 3'b001, 17'h00000, 8'h00);
    probe("R4", 24'h001FFF, 3'b001, 17'h01FFF, 8'h00);
    probe("R4", 24'h3F1234, 3'b001, 17'h01234, 8'h00);
    probe("R4", 24'h800ABC, 3'b001, 17'h00ABC, 8'h00);
    probe("R4", 24'hBF1FFF, 3'b001, 17'h01FFF, 8'h00);
  endtask

  task automatic t_regs; // R5, R9
    probe("R5", 24'h002000, 3'b010, 17'h0, 8'h00);
    probe("R5", 24'h3F2FFF, 3'b010, 17'h0, 8'h00);
    probe("R5", 24'h804000, 3'b010, 17'h0, 8'h00);
    probe("R5", 24'hBF4FFF, 3'b010, 17'h0, 8'h00);
  endtask

  task automatic t_unmapped; // R6, R7
    probe("R6", 24'h003000, 3'b100, 17'h0, 8'h03);
    probe("R6", 24'h005000, 3'b100, 17'h0, 8'h05);
    probe("R6", 24'h008000, 3'b100, 17'h0, 8'h08);
    probe("R7", 24'h400000, 3'b100, 17'h0, 8'h00);
    probe("R7", 24'h7D2000, 3'b100, 17'h0, 8'hD2);
    probe("R6", 24'hC00000, 3'b100, 17'h0, 8'h00);
    probe("R7", 24'hFFFFFF, 3'b100, 17'h0, 8'hFF);
    probe("R7", 24'h12F456, 3'b100, 17'h0, 8'h2F);
  endtask

  task automatic t_low_bits; // R8: low 12 bits never change the region
    for (int k = 0; k < 4096; k += 273) begin
      probe("R8", 24'h812000 | 24'(k), 3'b010, 17'h0, 8'h00);
      probe("R8", 24'hA06000 | 24'(k), 3'b100, 17'h0, 8'h06);
    end
  endtask

  task automatic t_hold; // R2
    probe("R2", 24'h7E1234, 3'b001, 17'h01234, 8'h00);
    @(negedge clk);
    in_addr = 24'h403000;
    @(negedge clk);
    cmp("R2", "valid after idle", 32'(out_valid), 32'd0);
    cmp("R2", "sel held", 32'(out_sel), 32'b001);
    cmp("R2", "wram held", 32'(out_wram_addr), 32'h01234);
  endtask

  initial begin
    t_reset();
    t_linear();
    t_mirror();
    t_regs();
    t_unmapped();
    t_low_bits();
    t_hold();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule